// File: doc/BRIEF.md
# Sleep-Mode Controller

This block sits between a small processor core and the clock-gating network of its chip. The core raises a one-cycle sleep strobe when it executes its sleep instruction. It also presents a sleep-enable bit and a 3-bit mode code taken from its control register. When the enable bit is set at the moment of the strobe and the code names a supported mode, the block freezes the core and drops the clock enables of the domains that the mode switches off. Register and memory contents are never cleared by this block.

While asleep, the block watches four wake sources:

- an enabled-interrupt request;
- an external interrupt line, which can present either a level or an edge;
- an event from a peripheral that can run from its own asynchronous clock;
- the block reset.

A qualified request passes through a two-flop synchroniser. All clocks are then restored, and the core stays halted for the mode's start-up delay plus four further cycles. After that the halt is released together with a one-cycle resume pulse. The start-up delays are cycle counts loaded from two inputs, one long and one short.

All pins are plain control and status signals. The block moves no data, so it has no valid/ready interface and applies no back-pressure.

Top module: `sleep_ctrl`

## Requirements
- R1: Sleep is entered only if `sleep_en` is 1 in the same cycle as a `sleep_strobe` that arrives while the core is running. A strobe with `sleep_en` at 0 leaves `core_halt` at 0 and all clock enables at 1.
- R2: The mode codes are 000 idle, 001 ADC noise reduction, 010 power-down, 011 power-save and 110 standby. The codes 100, 101 and 111 are ignored and the core keeps running.
- R3: One cycle after a valid entry, `core_halt` is 1. `clk_en` then follows the mode, with bit 0 CPU, bit 1 flash, bit 2 I/O, bit 3 ADC, bit 4 asynchronous timer and bit 5 main oscillator. The values are: idle 6'b111100, ADC noise reduction 6'b111000, power-down 6'b000000, power-save 6'b010000, standby 6'b100000.
- R4: `irq_wake` wakes every mode. If the request is driven just after clock edge 0, all clock enables return to 1 at edge 3. `core_halt` falls at edge D+7, where D is the mode's start-up delay: two synchroniser stages, one detection edge, D start-up cycles and a fixed four-cycle hold.
- R5: The start-up delay D is `dly_long` for power-down and power-save, `dly_short` for standby, and 0 for idle and ADC noise reduction.
- R6: A high level on `ext_lvl` wakes every mode. A pulse on `ext_edge` wakes only idle and ADC noise reduction, and is ignored in power-down, power-save and standby.
- R7: `async_evt` wakes only idle, ADC noise reduction and power-save, and only while `async_mode` is 1. Otherwise it is ignored.
- R8: `wake_pulse` is high for exactly the one cycle in which `core_halt` first reads 0 after a wake. Whenever `core_halt` is 0, all clock enables are 1.
- R9: While `rst_n` is low, including in the middle of a sleep, `core_halt` is 0, `clk_en` is all ones and `wake_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset; also a wake source |
| sleep_strobe | input | 1 | One-cycle pulse from the executed sleep instruction |
| sleep_en | input | 1 | Sleep-enable control bit |
| sleep_mode | input | 3 | Requested mode code |
| dly_long | input | DW | Start-up cycles for power-down and power-save |
| dly_short | input | DW | Start-up cycles for standby |
| irq_wake | input | 1 | An enabled interrupt is pending |
| ext_lvl | input | 1 | External interrupt, level request |
| ext_edge | input | 1 | External interrupt, edge event pulse |
| async_evt | input | 1 | Event from an asynchronous-clock peripheral |
| async_mode | input | 1 | That peripheral runs from its asynchronous clock |
| clk_en | output | 6 | Per-domain clock enables |
| core_halt | output | 1 | Core frozen |
| wake_pulse | output | 1 | One-cycle resume indication |

## Verification
The assertions take the following for granted about the inputs:

- `sleep_strobe` is a single-cycle pulse.
- `sleep_mode` and `sleep_en` are valid in the same cycle as the strobe.
- Wake inputs are synchronous pulses or levels that the driving logic holds until `core_halt` falls.
- The delay inputs do not change during a wake.

The stimulus keeps within these rules in the following ways. It drives every input on the falling edge and strobes only while the core runs. It holds level-type sources until release and gives edges exactly one cycle. It draws modes, enables, sources and delays from a fixed-seed random stream, mixed with directed cases for unused codes, masked sources and reset during sleep.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;
  localparam int NUM_DOM   = 6;
  localparam int DOM_CPU   = 0;
  localparam int DOM_FLASH = 1;
  localparam int DOM_IO    = 2;
  localparam int DOM_ADC   = 3;
  localparam int DOM_ATMR  = 4;
  localparam int DOM_OSC   = 5;
  localparam int WAKE_HOLD = 4;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'b000,
    MODE_ADCNR = 3'b001,
    MODE_PDOWN = 3'b010,
    MODE_PSAVE = 3'b011,
    MODE_STBY  = 3'b110
  } sleep_mode_e;

  typedef enum logic [1:0] {DLY_NONE, DLY_SHORT, DLY_LONG} dly_sel_e;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WAKE} seq_state_e;

  typedef struct packed {
    logic               valid;
    logic               edge_ok;
    logic               async_ok;
    dly_sel_e           dly;
    logic [NUM_DOM-1:0] clk_pat;
  } mode_cfg_t;
endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_ctrl_pkg::*;
(
  input  logic [2:0] mode_code,
  output mode_cfg_t  cfg
);
  always_comb begin
    cfg         = '0;
    cfg.clk_pat = '1;
    cfg.dly     = DLY_NONE;
    case (mode_code)
      MODE_IDLE: begin
        cfg.valid   = 1'b1;
        cfg.edge_ok = 1'b1;
        cfg.async_ok = 1'b1;
        cfg.clk_pat[DOM_CPU]   = 1'b0;
        cfg.clk_pat[DOM_FLASH] = 1'b0;
      end
      MODE_ADCNR: begin
        cfg.valid   = 1'b1;
        cfg.edge_ok = 1'b1;
        cfg.async_ok = 1'b1;
        cfg.clk_pat[DOM_CPU]   = 1'b0;
        cfg.clk_pat[DOM_FLASH] = 1'b0;
        cfg.clk_pat[DOM_IO]    = 1'b0;
      end
      MODE_PDOWN: begin
        cfg.valid   = 1'b1;
        cfg.clk_pat = '0;
        cfg.dly     = DLY_LONG;
      end
      MODE_PSAVE: begin
        cfg.valid    = 1'b1;
        cfg.async_ok = 1'b1;
        cfg.clk_pat  = '0;
        cfg.clk_pat[DOM_ATMR] = 1'b1;
        cfg.dly      = DLY_LONG;
      end
      MODE_STBY: begin
        cfg.valid   = 1'b1;
        cfg.clk_pat = '0;
        cfg.clk_pat[DOM_OSC] = 1'b1;
        cfg.dly     = DLY_SHORT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asleep,
  input  logic edge_ok,
  input  logic async_ok,
  input  logic irq_wake,
  input  logic ext_lvl,
  input  logic ext_edge,
  input  logic async_evt,
  input  logic async_mode,
  output logic wake_sync
);
  logic                   raw_req;
  logic [SYNC_STAGES-1:0] stg_q;

  assign raw_req = asleep & (irq_wake | ext_lvl | (ext_edge & edge_ok) |
                             (async_evt & async_mode & async_ok));

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= raw_req;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[SYNC_STAGES-2:0], raw_req};
      end
    end
  endgenerate

  assign wake_sync = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_ctrl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_strobe,
  input  logic               sleep_en,
  input  mode_cfg_t          cfg_in,
  input  logic               wake_sync,
  input  logic [DW-1:0]      dly_long,
  input  logic [DW-1:0]      dly_short,
  output logic               asleep,
  output logic               held_edge_ok,
  output logic               held_async_ok,
  output logic [NUM_DOM-1:0] clk_en,
  output logic               core_halt,
  output logic               wake_pulse
);
  localparam int CW = DW + 1;

  seq_state_e         state_q;
  mode_cfg_t          held_q;
  logic [CW-1:0]      cnt_q;
  logic [CW-1:0]      dly_ext;
  logic [NUM_DOM-1:0] en_q;
  logic               pulse_q;

  always_comb begin
    case (held_q.dly)
      DLY_LONG:  dly_ext = CW'(dly_long);
      DLY_SHORT: dly_ext = CW'(dly_short);
      default:   dly_ext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      held_q  <= '0;
      cnt_q   <= '0;
      en_q    <= '1;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (sleep_strobe && sleep_en && cfg_in.valid) begin
            state_q <= ST_SLEEP;
            held_q  <= cfg_in;
            en_q    <= cfg_in.clk_pat;
          end
        end
        ST_SLEEP: begin
          if (wake_sync) begin
            state_q <= ST_WAKE;
            en_q    <= '1;
            cnt_q   <= dly_ext + CW'(WAKE_HOLD - 1);
          end
        end
        ST_WAKE: begin
          if (cnt_q == '0) begin
            state_q <= ST_RUN;
            pulse_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign asleep        = (state_q == ST_SLEEP);
  assign held_edge_ok  = held_q.edge_ok;
  assign held_async_ok = held_q.async_ok;
  assign clk_en        = en_q;
  assign core_halt     = (state_q != ST_RUN);
  assign wake_pulse    = pulse_q;
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_strobe,
  input  logic               sleep_en,
  input  logic [2:0]         sleep_mode,
  input  logic [DW-1:0]      dly_long,
  input  logic [DW-1:0]      dly_short,
  input  logic               irq_wake,
  input  logic               ext_lvl,
  input  logic               ext_edge,
  input  logic               async_evt,
  input  logic               async_mode,
  output logic [NUM_DOM-1:0] clk_en,
  output logic               core_halt,
  output logic               wake_pulse
);
  mode_cfg_t cfg_in;
  logic      asleep;
  logic      held_edge_ok;
  logic      held_async_ok;
  logic      wake_sync;

  sleep_mode_decode dec_i (
    .mode_code (sleep_mode),
    .cfg       (cfg_in)
  );

  sleep_wake_qual #(.SYNC_STAGES(SYNC_STAGES)) qual_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .asleep     (asleep),
    .edge_ok    (held_edge_ok),
    .async_ok   (held_async_ok),
    .irq_wake   (irq_wake),
    .ext_lvl    (ext_lvl),
    .ext_edge   (ext_edge),
    .async_evt  (async_evt),
    .async_mode (async_mode),
    .wake_sync  (wake_sync)
  );

  sleep_seq #(.DW(DW)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_strobe  (sleep_strobe),
    .sleep_en      (sleep_en),
    .cfg_in        (cfg_in),
    .wake_sync     (wake_sync),
    .dly_long      (dly_long),
    .dly_short     (dly_short),
    .asleep        (asleep),
    .held_edge_ok  (held_edge_ok),
    .held_async_ok (held_async_ok),
    .clk_en        (clk_en),
    .core_halt     (core_halt),
    .wake_pulse    (wake_pulse)
  );
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
  parameter int NUM_DOM = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sleep_strobe,
  input logic               sleep_en,
  input logic [2:0]         sleep_mode,
  input logic [NUM_DOM-1:0] clk_en,
  input logic               core_halt,
  input logic               wake_pulse
);
  // R1
  no_en_no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_strobe && !sleep_en) |=> !core_halt);

  // R1
  halt_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) |-> $past(sleep_strobe && sleep_en));

  // R2
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_strobe &&
     (sleep_mode == 3'b100 || sleep_mode == 3'b101 || sleep_mode == 3'b111))
    |=> !core_halt);

  // R3
  pdown_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_strobe && sleep_en && sleep_mode == 3'b010)
    |=> (clk_en == '0));

  // R8
  run_clocks_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halt |-> (&clk_en));

  // R8
  pulse_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!core_halt && $past(core_halt)));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
endmodule

bind sleep_ctrl sleep_ctrl_chk #(.NUM_DOM(sleep_ctrl_pkg::NUM_DOM)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_strobe (sleep_strobe),
  .sleep_en     (sleep_en),
  .sleep_mode   (sleep_mode),
  .clk_en       (clk_en),
  .core_halt    (core_halt),
  .wake_pulse   (wake_pulse)
);

// File: tb/sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_ctrl_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_strobe = 1'b0;
  logic          sleep_en = 1'b0;
  logic [2:0]    sleep_mode = 3'b000;
  logic [DW-1:0] dly_long = '0;
  logic [DW-1:0] dly_short = '0;
  logic          irq_wake = 1'b0;
  logic          ext_lvl = 1'b0;
  logic          ext_edge = 1'b0;
  logic          async_evt = 1'b0;
  logic          async_mode = 1'b0;
  logic [5:0]    clk_en;
  logic          core_halt;
  logic          wake_pulse;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sleep_ctrl #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .sleep_en(sleep_en),
    .sleep_mode(sleep_mode), .dly_long(dly_long), .dly_short(dly_short),
    .irq_wake(irq_wake), .ext_lvl(ext_lvl), .ext_edge(ext_edge),
    .async_evt(async_evt), .async_mode(async_mode),
    .clk_en(clk_en), .core_halt(core_halt), .wake_pulse(wake_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_valid(input logic [2:0] m);
    return m inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110};
  endfunction

  function automatic logic [5:0] exp_pat(input logic [2:0] m);
    case (m)
      3'b000:  return 6'b111100;
      3'b001:  return 6'b111000;
      3'b010:  return 6'b000000;
      3'b011:  return 6'b010000;
      3'b110:  return 6'b100000;
      default: return 6'b111111;
    endcase
  endfunction

  function automatic int exp_dly(input logic [2:0] m, input int ld, input int sd);
    if (m == 3'b010 || m == 3'b011) return ld;
    if (m == 3'b110) return sd;
    return 0;
  endfunction

  // src: 0 irq, 1 level, 2 edge, 3 async event
  function automatic bit src_wakes(input logic [2:0] m, input int src, input bit am);
    case (src)
      0, 1:    return 1'b1;
      2:       return (m == 3'b000 || m == 3'b001);
      default: return am && (m == 3'b000 || m == 3'b001 || m == 3'b011);
    endcase
  endfunction

  function automatic string src_req(input int src);
    case (src)
      1, 2:    return "R6";
      3:       return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic drive_src(input int src, input bit v);
    case (src)
      0:       irq_wake  = v;
      1:       ext_lvl   = v;
      2:       ext_edge  = v;
      default: async_evt = v;
    endcase
  endtask

  task automatic enter(input logic [2:0] m, input bit en);
    @(negedge clk);
    sleep_mode = m; sleep_en = en; sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0;
  endtask

  task automatic wake_measure(input int src, input int d, input string req);
    int n = 0;
    drive_src(src, 1'b1);
    while (n < 100000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) ext_edge = 1'b0;
      if (n == 3) chk(clk_en == 6'b111111, "R4 clocks restored", int'(clk_en), 63);
      if (!core_halt) break;
    end
    chk(n == d + 7, (d == 0) ? req : "R5", n, d + 7);
    chk(wake_pulse == 1'b1, "R8 pulse", int'(wake_pulse), 1);
    irq_wake = 1'b0; ext_lvl = 1'b0; ext_edge = 1'b0; async_evt = 1'b0;
    @(negedge clk);
    chk(wake_pulse == 1'b0, "R8 single", int'(wake_pulse), 0);
  endtask

  task automatic run_case(input logic [2:0] m, input bit en, input int src,
                          input bit am, input int ld, input int sd);
    dly_long = DW'(ld); dly_short = DW'(sd); async_mode = am;
    enter(m, en);
    if (!(en && exp_valid(m))) begin
      chk(core_halt == 1'b0, en ? "R2" : "R1", int'(core_halt), 0);
      chk(clk_en == 6'b111111, en ? "R2" : "R1", int'(clk_en), 63);
      return;
    end
    chk(core_halt == 1'b1, "R1 entry", int'(core_halt), 1);
    chk(clk_en == exp_pat(m), "R3", int'(clk_en), int'(exp_pat(m)));
    repeat (2) @(negedge clk);
    if (!src_wakes(m, src, am)) begin
      drive_src(src, 1'b1);
      @(negedge clk);
      ext_edge = 1'b0;
      repeat (7) @(negedge clk);
      drive_src(src, 1'b0);
      chk(core_halt == 1'b1 && clk_en == exp_pat(m), src_req(src),
          int'(clk_en), int'(exp_pat(m)));
      wake_measure(0, exp_dly(m, ld, sd), "R4");
    end else begin
      wake_measure(src, exp_dly(m, ld, sd), src_req(src));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] modes [5];
    modes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110};
    void'($urandom(32'h51ee9));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(core_halt == 1'b0 && wake_pulse == 1'b0, "R9 reset", int'(core_halt), 0);
    chk(clk_en == 6'b111111, "R9 reset", int'(clk_en), 63);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) run_case(modes[i], 1'b1, 0, 1'b0, 5, 2);
    run_case(3'b010, 1'b0, 0, 1'b0, 3, 3);           // R1
    run_case(3'b101, 1'b1, 0, 1'b0, 3, 3);           // R2
    run_case(3'b111, 1'b1, 0, 1'b0, 3, 3);           // R2
    run_case(3'b100, 1'b1, 0, 1'b0, 3, 3);           // R2
    run_case(3'b010, 1'b1, 2, 1'b0, 4, 1);           // R6 edge masked
    run_case(3'b110, 1'b1, 2, 1'b0, 4, 1);           // R6 edge masked
    run_case(3'b000, 1'b1, 2, 1'b0, 4, 1);           // R6 edge wakes
    run_case(3'b110, 1'b1, 1, 1'b0, 4, 6);           // R6 level wakes
    run_case(3'b011, 1'b1, 3, 1'b0, 2, 1);           // R7 not async
    run_case(3'b010, 1'b1, 3, 1'b1, 2, 1);           // R7 wrong mode
    run_case(3'b011, 1'b1, 3, 1'b1, 2, 1);           // R7 wakes
    run_case(3'b010, 1'b1, 0, 1'b0, 1000, 0);        // R5 long delay

    // R9 reset during sleep
    enter(3'b010, 1'b1);
    chk(core_halt == 1'b1, "R9 pre", int'(core_halt), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(core_halt == 1'b0 && wake_pulse == 1'b0, "R9 sleep reset", int'(core_halt), 0);
    chk(clk_en == 6'b111111, "R9 sleep reset", int'(clk_en), 63);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 150; k++) begin
      logic [2:0] m;
      m = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 7))
                                      : modes[$urandom_range(0, 4)];
      run_case(m, ($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
               int'($urandom_range(0, 15)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule